// File: doc/BRIEF.md
# Runtime-Configurable Programmable Logic Array

This block is a two-level programmable logic array. Its AND plane, OR plane and per-output polarity are held in registers rather than fixed at build time. A narrow write port loads the configuration one word at a time. The address picks either one product-term row or the polarity word.

Once loaded, the array works purely combinationally. The `N_IN` inputs, each in true and complement form, feed `N_TERM` product terms. Any product term can drive any number of the `N_OUT` sum outputs, so one term may be shared. Each sum passes through an exclusive-OR stage whose second input is a stored polarity bit, so any output can deliver either its sum of products or the complement of that sum.

The default build has 3 inputs, 4 terms and 2 outputs. A full-size build of 16 inputs, 48 terms and 8 outputs is supported by the same parameters.

Top module: `prog_logic_array`

## Requirements
- R1: The synchronous active-low reset clears every row and the polarity word to zero, so `dout` reads all zeros for every `din` value.
- R2: A write with `cfg_addr` below `N_TERM` replaces that row with `cfg_wdata` at the next rising clock edge; before that edge `dout` still reflects the old row. In a row, bit 2i enables the true form of `din[i]`, bit 2i+1 enables its complement, and bit 2*`N_IN`+j connects the term to output j.
- R3: A product term with no input enables evaluates to 1.
- R4: A product term that enables both the true and the complement form of the same input evaluates to 0.
- R5: One product term connected to several outputs drives all of them.
- R6: A write at `cfg_addr` equal to `N_TERM` loads the polarity word from `cfg_wdata[N_OUT-1:0]`; polarity bit j set makes `dout[j]` the complement of its sum, and clear passes the sum unchanged.
- R7: An output with no connected terms has a sum of 0, so it reads back its polarity bit.
- R8: A write at any address above `N_TERM` changes no row and no polarity bit.
- R9: `dout` follows `din` combinationally, with no clock edge needed.
- R10: With A=`din[2]`, B=`din[1]` and C=`din[0]`, the block can be programmed to give output 0 = AB'+AC+A'BC' and output 1 = (AC+BC)'. The term AC is shared between the two outputs, and the polarity bit of output 1 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(N_TERM+1) | Row index, or `N_TERM` for the polarity word |
| cfg_wdata | input | 2*N_IN+N_OUT | Configuration word to store |
| din | input | N_IN | Logic inputs |
| dout | output | N_OUT | Logic outputs after polarity |

## Verification
The hardest condition to reach from the ports is a single term that reaches several outputs with different polarities. In that case one stored row decides two outputs that must come out opposite. The stimulus loads one row connected to both outputs, then flips only the polarity word, so both outputs move from one `din` edge while pointing in opposite directions. The degenerate terms are reached the same way: an all-empty row and a row with a conflicting pair of enables are each loaded alone after a reset. The bench then sweeps `din` so that the lone term decides the output unaided.

// File: rtl/pla_pkg.sv
// pla_pkg: shared types and helpers for the programmable logic array.
// Assumes: addresses below the row count select a row, the next address
// selects the polarity word, and anything higher is unused.
package pla_pkg;

    // Kind of register a configuration address selects
    typedef enum logic [1:0] {
        TGT_ROW  = 2'd0,
        TGT_POL  = 2'd1,
        TGT_NONE = 2'd2
    } cfg_target_e;

    // Map an address onto the register kind it selects
    function automatic cfg_target_e classify(input int unsigned addr,
                                             input int unsigned n_term);
        if (addr < n_term)
            return TGT_ROW;
        else if (addr == n_term)
            return TGT_POL;
        else
            return TGT_NONE;
    endfunction

endpackage

// File: rtl/pla_cfg_regs.sv
// pla_cfg_regs: holds the product-term rows and the output polarity word.
// Assumes: one write per cycle, taking effect at the rising edge;
// synchronous active-low reset clears every stored bit.
module pla_cfg_regs #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2,
    localparam int ROW_W  = 2 * N_IN + N_OUT,
    localparam int ADDR_W = $clog2(N_TERM + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [ROW_W-1:0]              cfg_wdata,
    output logic [N_TERM-1:0][ROW_W-1:0]  rows,
    output logic [N_OUT-1:0]              pol
);

    pla_pkg::cfg_target_e tgt;
    logic [N_TERM-1:0]    row_we;
    logic                 pol_we;

    // Decode the write address into per-row and polarity strobes
    always_comb begin
        tgt    = pla_pkg::classify(32'(cfg_addr), N_TERM);
        pol_we = cfg_we && (tgt == pla_pkg::TGT_POL);
        for (int t = 0; t < N_TERM; t++) begin
            row_we[t] = cfg_we && (tgt == pla_pkg::TGT_ROW) &&
                        (cfg_addr == ADDR_W'(t));
        end
    end

    // Store row words on their strobes, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows <= '0;
        end else begin
            for (int t = 0; t < N_TERM; t++) begin
                if (row_we[t])
                    rows[t] <= cfg_wdata;
            end
        end
    end

    // Store the polarity word from the low data bits, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            pol <= '0;
        else if (pol_we)
            pol <= cfg_wdata[N_OUT-1:0];
    end

endmodule

// File: rtl/pla_and_plane.sv
// pla_and_plane: forms every product term from the inputs and the stored
// enables. Assumes enable bit 2i selects the true form of input i and bit
// 2i+1 its complement; an unused input does not restrict the term.
module pla_and_plane #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4
) (
    input  logic [N_IN-1:0]                  din,
    input  logic [N_TERM-1:0][2*N_IN-1:0]    and_en,
    output logic [N_TERM-1:0]                term_val
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_IN-1:0] lit_ok;

        // Each literal passes unless an enabled form disagrees with the input
        always_comb begin
            for (int i = 0; i < N_IN; i++) begin
                lit_ok[i] = (!and_en[t][2*i]   ||  din[i]) &&
                            (!and_en[t][2*i+1] || !din[i]);
            end
        end

        // The term is the AND of all its literal checks
        assign term_val[t] = &lit_ok;
    end

endmodule

// File: rtl/pla_or_plane.sv
// pla_or_plane: sums the connected terms for each output, then applies the
// programmable inversion. Assumes an output with no connections sums to 0.
module pla_or_plane #(
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2
) (
    input  logic [N_TERM-1:0]               term_val,
    input  logic [N_OUT-1:0][N_TERM-1:0]    conn,
    input  logic [N_OUT-1:0]                pol,
    output logic [N_OUT-1:0]                dout
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic sum;

        // OR of the terms wired to this output
        assign sum = |(term_val & conn[o]);

        // Exclusive-OR with the stored polarity bit
        assign dout[o] = sum ^ pol[o];
    end

endmodule

// File: rtl/prog_logic_array.sv
// prog_logic_array: runtime-configurable two-level logic array with
// programmable AND plane, OR plane and output polarity.
// Assumes: row word = {output connections, input enables}; the polarity
// word is at address N_TERM; outputs are combinational from din.
module prog_logic_array #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2,
    localparam int ROW_W  = 2 * N_IN + N_OUT,
    localparam int ADDR_W = $clog2(N_TERM + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [ROW_W-1:0]   cfg_wdata,
    input  logic [N_IN-1:0]    din,
    output logic [N_OUT-1:0]   dout
);

    logic [N_TERM-1:0][ROW_W-1:0]   cfg_rows;
    logic [N_OUT-1:0]               cfg_pol;
    logic [N_TERM-1:0][2*N_IN-1:0]  and_en;
    logic [N_OUT-1:0][N_TERM-1:0]   conn;
    logic [N_TERM-1:0]              term_val;

    pla_cfg_regs #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rows      (cfg_rows),
        .pol       (cfg_pol)
    );

    // Split each row into its enable field and its connection field
    always_comb begin
        for (int t = 0; t < N_TERM; t++) begin
            and_en[t] = cfg_rows[t][2*N_IN-1:0];
            for (int o = 0; o < N_OUT; o++) begin
                conn[o][t] = cfg_rows[t][2*N_IN+o];
            end
        end
    end

    pla_and_plane #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM)
    ) i_and (
        .din      (din),
        .and_en   (and_en),
        .term_val (term_val)
    );

    pla_or_plane #(
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT)
    ) i_or (
        .term_val (term_val),
        .conn     (conn),
        .pol      (cfg_pol),
        .dout     (dout)
    );

endmodule

// File: rtl/pla_checker.sv
// pla_checker: properties for prog_logic_array, bound to every instance.
// Assumes: synchronous active-low reset held for at least one edge.
module pla_checker #(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2,
    localparam int ROW_W  = 2 * N_IN + N_OUT,
    localparam int ADDR_W = $clog2(N_TERM + 1)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_we,
    input logic [ADDR_W-1:0]             cfg_addr,
    input logic [ROW_W-1:0]              cfg_wdata,
    input logic [N_TERM-1:0][ROW_W-1:0]  rows,
    input logic [N_OUT-1:0]              pol,
    input logic [N_TERM-1:0]             terms,
    input logic [N_OUT-1:0]              dout
);

    logic              rst_seen_q;
    logic [N_TERM-1:0] empty_t;
    logic [N_TERM-1:0] clash_t;
    logic [N_OUT-1:0]  hit_o;
    logic [N_OUT-1:0]  bare_o;

    // Remember that reset was sampled low at the previous edge
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Classify rows and outputs from the stored configuration
    always_comb begin
        for (int t = 0; t < N_TERM; t++) begin
            empty_t[t] = (rows[t][2*N_IN-1:0] == '0);
            clash_t[t] = 1'b0;
            for (int i = 0; i < N_IN; i++)
                clash_t[t] = clash_t[t] || (rows[t][2*i] && rows[t][2*i+1]);
        end
        for (int o = 0; o < N_OUT; o++) begin
            hit_o[o]  = 1'b0;
            bare_o[o] = 1'b1;
            for (int t = 0; t < N_TERM; t++) begin
                hit_o[o]  = hit_o[o]  || (terms[t] && rows[t][2*N_IN+o]);
                bare_o[o] = bare_o[o] && !rows[t][2*N_IN+o];
            end
        end
    end

    // Output is cleared one edge after reset was applied
    always @(posedge clk) begin
        if (rst_seen_q && rst_n)
            AST_RESET_CLEARS_OUT: assert (dout == '0); // R1
    end

    AST_IDLE_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(rows) && $stable(pol))); // R2

    AST_POL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_W'(N_TERM)) |=>
        (pol == $past(cfg_wdata[N_OUT-1:0]))); // R6

    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr > ADDR_W'(N_TERM)) |=>
        ($stable(rows) && $stable(pol))); // R8

    for (genvar t = 0; t < N_TERM; t++) begin : g_tchk
        AST_ROW_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == ADDR_W'(t)) |=>
            (rows[t] == $past(cfg_wdata))); // R2

        AST_EMPTY_TERM_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
            empty_t[t] |-> terms[t]); // R3

        AST_CLASH_TERM_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
            clash_t[t] |-> !terms[t]); // R4
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_ochk
        AST_HIT_FOLLOWS_POL: assert property (@(posedge clk) disable iff (!rst_n)
            hit_o[o] |-> (dout[o] == !pol[o])); // R5 R6

        AST_BARE_OUT_IS_POL: assert property (@(posedge clk) disable iff (!rst_n)
            bare_o[o] |-> (dout[o] == pol[o])); // R7
    end

endmodule

bind prog_logic_array pla_checker #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT)
) i_pla_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .rows      (cfg_rows),
    .pol       (cfg_pol),
    .terms     (term_val),
    .dout      (dout)
);

// File: tb/test_prog_logic_array.sv
// Bench for prog_logic_array at default parameters (3 in, 4 terms, 2 out).
// Row word: [1:0] din[0] true/comp, [3:2] din[1], [5:4] din[2], [7:6] outputs.
module test_prog_logic_array;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [2:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [2:0] din;
    logic [1:0] dout;

    int n_chk  = 0;
    int n_fail = 0;

    // {din, expected dout} for out0 = AB'+AC+A'BC', out1 = (AC+BC)'
    localparam logic [4:0] VEC_TBL [8] = '{
        5'b000_10, 5'b001_10, 5'b010_11, 5'b011_00,
        5'b100_11, 5'b101_01, 5'b110_10, 5'b111_01
    };

    prog_logic_array i_prog_logic_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .din       (din),
        .dout      (dout)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic apply(input logic [2:0] v);
        din = v;
        #1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; din = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared configuration gives zeros for every input
        for (int v = 0; v < 8; v++) begin
            apply(3'(v));
            check("R1 reset state", dout, 2'b00);
        end

        // R7: no connections, polarity 11 -> outputs read polarity
        wr(3'd4, 8'h03);
        apply(3'b101);
        check("R7 bare outputs", dout, 2'b11);
        wr(3'd4, 8'h00);

        // R2: row 0 = C true, out0; visible only after the edge
        apply(3'b001);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'h41;
        #1;
        check("R2 before edge", dout, 2'b00);
        @(posedge clk);
        #1;
        check("R2 after edge", dout, 2'b01);
        @(negedge clk);
        cfg_we = 1'b0;

        // R9: output follows din without a clock edge
        #2; din = 3'b000; #1;
        check("R9 din low", dout, 2'b00);
        #1; din = 3'b001; #1;
        check("R9 din high", dout, 2'b01);

        // R5: term C shared by both outputs
        wr(3'd0, 8'hC1);
        apply(3'b001);
        check("R5 shared high", dout, 2'b11);
        apply(3'b000);
        check("R5 shared low", dout, 2'b00);

        // R6: invert out0 only, shared term drives opposite values
        wr(3'd4, 8'h01);
        apply(3'b001);
        check("R6 polarity C=1", dout, 2'b10);
        apply(3'b000);
        check("R6 polarity C=0", dout, 2'b01);

        // R3: empty term on out0 is always true
        do_reset();
        wr(3'd0, 8'h40);
        apply(3'b000);
        check("R3 empty term 000", dout, 2'b01);
        apply(3'b111);
        check("R3 empty term 111", dout, 2'b01);

        // R4: both forms of din[2] enabled -> term false
        wr(3'd0, 8'h70);
        apply(3'b100);
        check("R4 clash A=1", dout, 2'b00);
        apply(3'b000);
        check("R4 clash A=0", dout, 2'b00);

        // R10: program two-function example and walk the table
        wr(3'd0, 8'h58);
        wr(3'd1, 8'hD1);
        wr(3'd2, 8'h66);
        wr(3'd3, 8'h85);
        wr(3'd4, 8'h02);
        for (int v = 0; v < 8; v++) begin
            apply(VEC_TBL[v][4:2]);
            check("R10 example", dout, VEC_TBL[v][1:0]);
        end

        // R8: writes above the polarity address change nothing
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'h00);
        for (int v = 0; v < 8; v++) begin
            apply(VEC_TBL[v][4:2]);
            check("R8 unused address", dout, VEC_TBL[v][1:0]);
        end

        // R1: a second reset clears a loaded configuration
        do_reset();
        apply(3'b010);
        check("R1 reset after load", dout, 2'b00);
        apply(3'b101);
        check("R1 reset after load", dout, 2'b00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule